// File: doc/BRIEF.md
# Sixteen-Bit Fast PWM Timer with Two Compare Channels

This block is an up-counting 16-bit timer that produces two pulse-width modulated outputs. One programmable TOP value sets the period and each channel has its own compare value. The counter runs from zero up to TOP, returns to zero (BOTTOM) and starts again. Each channel sets or clears its pin at BOTTOM and does the opposite when the count equals its compare value, so the pulse width follows the compare value.

A three-bit clock select picks what advances the counter: nothing, the system clock, the system clock divided by 8, 64, 256 or 1024, or an edge of an external pin. The external pin is synchronised before its edges are detected. The TOP and compare values are written into buffers and become active only when the counter wraps, so a change in the middle of a period cannot produce a short or split pulse.

Each channel has a two-bit output mode. A direction input gates the pin driver, so a connected channel drives its pin only when that input is set. A second waveform mode uses the channel A compare value as TOP. In that mode channel A can toggle its pin once per period, which gives a square wave.

Top module: `pwm_timer16`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `cnt_o` is 0 and `pwm_a`, `pwm_b`, `oe_a` and `oe_b` are all 0.
- R2: On every counter tick, the count goes from the active TOP value back to 0. From any other value it increments by one. One period is therefore TOP+1 ticks.
- R3: Clock select encoding:
  - 000: no ticks; the count holds.
  - 001: a tick on every clock.
  - 010, 011, 100, 101: a tick on the clocks where the low 3, 6, 8 or 10 bits of a free-running prescaler are all ones. The prescaler is cleared by reset and counts every clock.
- R4: Clock select 110 counts falling edges of `ext_clk` and 111 counts rising edges. A level sampled at clock edge k advances the counter at clock edge k+2.
- R5: Output mode 10 (non-inverting) sets the pin when the count wraps to BOTTOM and clears it on the tick where the count equals the compare value. The pin is high while the count is in 0..compare.
- R6: Output mode 11 (inverting) clears the pin at BOTTOM and sets it on a compare match.
- R7: A compare value equal to TOP ignores the match while the mode's high bit is set, so mode 10 stays high and mode 11 stays low. A compare value of 0 in mode 10 gives a pulse of exactly one count per period.
- R8: Output mode 01 toggles channel A on each compare match, but only in waveform mode 15. In any other waveform mode it leaves channel A disconnected. Channel B is always disconnected under 01.
- R9: A disconnected channel drives its pin at 0 and its enable at 0. A connected channel asserts its output enable only when its direction input is 1.
- R10: Writes to TOP and to the compare values go to buffers. The buffers are copied to the active registers on the tick where the count wraps, so a write in mid-period does not change the current period.
- R11: With waveform mode 15 the active channel A compare value is used as TOP. Every other waveform mode value behaves as mode 14, which uses the separate TOP register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select (R3, R4) |
| wave_mode | input | 4 | Waveform mode: 15 takes TOP from compare A, other values use the TOP register |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| dir_a | input | 1 | Channel A pin direction (driver allowed) |
| dir_b | input | 1 | Channel B pin direction (driver allowed) |
| ext_clk | input | 1 | External count source, asynchronous |
| top_wr | input | 1 | Write strobe for the TOP buffer |
| top_din | input | 16 | TOP write data |
| cmp_a_wr | input | 1 | Write strobe for the channel A compare buffer |
| cmp_a_din | input | 16 | Channel A compare write data |
| cmp_b_wr | input | 1 | Write strobe for the channel B compare buffer |
| cmp_b_din | input | 16 | Channel B compare write data |
| cnt_o | output | 16 | Current count |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A pin driver enable |
| oe_b | output | 1 | Channel B pin driver enable |

## Verification
Three things can fall on the same tick: the wrap to BOTTOM, a compare match, and the buffer copy. A compare value equal to TOP makes the match and the wrap coincide. The bench checks that the BOTTOM action wins, so the pin stays at a constant level. It also writes a new TOP while the count is in mid-period and confirms that the count still reaches the old TOP before the new value takes effect. A behavioural model that updates the buffers only after the wrap decision judges every clock.

// File: rtl/pwm_timer16_pkg.sv
package pwm_timer16_pkg;

  localparam logic [3:0] WM_TOP_FROM_REG = 4'd14;
  localparam logic [3:0] WM_TOP_FROM_CMPA = 4'd15;

  localparam logic [1:0] OM_OFF    = 2'b00;
  localparam logic [1:0] OM_TOGGLE = 2'b01;
  localparam logic [1:0] OM_NONINV = 2'b10;
  localparam logic [1:0] OM_INV    = 2'b11;

  // number of low prescaler bits that must be all ones for a tick
  function automatic int unsigned presc_bits(input logic [2:0] sel);
    case (sel)
      3'b010:  return 3;
      3'b011:  return 6;
      3'b100:  return 8;
      3'b101:  return 10;
      default: return 0;
    endcase
  endfunction

  // may the toggle code drive this channel in this waveform mode
  function automatic logic toggle_allowed(input logic [1:0] om, input logic is_a,
                                          input logic [3:0] wm);
    return is_a && (om == OM_TOGGLE) && (wm == WM_TOP_FROM_CMPA);
  endfunction

  // is the channel's pin owned by the compare unit
  function automatic logic chan_connected(input logic [1:0] om, input logic is_a,
                                          input logic [3:0] wm);
    return om[1] || toggle_allowed(om, is_a, wm);
  endfunction

  // waveform level after a tick: BOTTOM action has priority over a match
  function automatic logic next_level(input logic [1:0] om, input logic cur,
                                      input logic at_bottom, input logic hit,
                                      input logic tgl_ok);
    if (om[1]) begin
      if (at_bottom) return ~om[0];
      if (hit) return om[0];
      return cur;
    end
    if (tgl_ok && hit) return ~cur;
    return cur;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRESC_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       ext_clk,
  output logic       tick
);
  import pwm_timer16_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [PRESC_W-1:0]     presc_q;
  logic [PRESC_W-1:0]     presc_mask;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_rise;
  logic                   ext_fall;
  logic                   presc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_q + 1'b1;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_clk;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign ext_rise   = sync_q[LAST] & ~prev_q;
  assign ext_fall   = ~sync_q[LAST] & prev_q;
  assign presc_mask = PRESC_W'((32'd1 << presc_bits(clk_sel)) - 32'd1);
  assign presc_hit  = ((presc_q & presc_mask) == presc_mask);

  always_comb begin
    case (clk_sel)
      3'b000:  tick = 1'b0;
      3'b110:  tick = ext_fall;
      3'b111:  tick = ext_rise;
      default: tick = presc_hit;
    endcase
  end

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       wave_mode,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_din,
  input  logic             cmp_a_wr,
  input  logic [CNT_W-1:0] cmp_a_din,
  input  logic             cmp_b_wr,
  input  logic [CNT_W-1:0] cmp_b_din,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_eff,
  output logic [CNT_W-1:0] cmp_a_act,
  output logic [CNT_W-1:0] cmp_b_act,
  output logic             wrap
);
  import pwm_timer16_pkg::*;

  logic [CNT_W-1:0] top_buf, cmp_a_buf, cmp_b_buf, top_act;

  assign top_eff = (wave_mode == WM_TOP_FROM_CMPA) ? cmp_a_act : top_act;
  assign wrap    = tick && (cnt == top_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_buf   <= '0;
      cmp_a_buf <= '0;
      cmp_b_buf <= '0;
    end else begin
      if (top_wr)   top_buf   <= top_din;
      if (cmp_a_wr) cmp_a_buf <= cmp_a_din;
      if (cmp_b_wr) cmp_b_buf <= cmp_b_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      top_act   <= '0;
      cmp_a_act <= '0;
      cmp_b_act <= '0;
    end else if (wrap) begin
      cnt       <= '0;
      top_act   <= top_buf;
      cmp_a_act <= cmp_a_buf;
      cmp_b_act <= cmp_b_buf;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int   CNT_W = 16,
  parameter logic IS_A  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] top_eff,
  input  logic [1:0]       om,
  input  logic [3:0]       wave_mode,
  input  logic             dir,
  output logic             hit,
  output logic             pin,
  output logic             oe
);
  import pwm_timer16_pkg::*;

  logic level_q;
  logic ignore_match;
  logic owned;

  assign ignore_match = om[1] && (cmp == top_eff);
  assign hit          = tick && (cnt == cmp) && !ignore_match;
  assign owned        = chan_connected(om, IS_A, wave_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else if (tick)
      level_q <= next_level(om, level_q, wrap, hit, toggle_allowed(om, IS_A, wave_mode));
  end

  assign pin = owned & level_q;
  assign oe  = owned & dir;

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16 #(
  parameter int CNT_W = 16,
  parameter int PRESC_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic [3:0]       wave_mode,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             dir_a,
  input  logic             dir_b,
  input  logic             ext_clk,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_din,
  input  logic             cmp_a_wr,
  input  logic [CNT_W-1:0] cmp_a_din,
  input  logic             cmp_b_wr,
  input  logic [CNT_W-1:0] cmp_b_din,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             oe_a,
  output logic             oe_b
);

  logic             tick;
  logic             wrap;
  logic             hit_a;
  logic             hit_b;
  logic [CNT_W-1:0] top_eff;
  logic [CNT_W-1:0] cmp_a_act;
  logic [CNT_W-1:0] cmp_b_act;

  pwm_tick_gen #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk), .tick(tick)
  );

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
    .top_wr(top_wr), .top_din(top_din),
    .cmp_a_wr(cmp_a_wr), .cmp_a_din(cmp_a_din),
    .cmp_b_wr(cmp_b_wr), .cmp_b_din(cmp_b_din),
    .cnt(cnt_o), .top_eff(top_eff), .cmp_a_act(cmp_a_act), .cmp_b_act(cmp_b_act),
    .wrap(wrap)
  );

  pwm_cmp_chan #(.CNT_W(CNT_W), .IS_A(1'b1)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt_o),
    .cmp(cmp_a_act), .top_eff(top_eff), .om(mode_a), .wave_mode(wave_mode),
    .dir(dir_a), .hit(hit_a), .pin(pwm_a), .oe(oe_a)
  );

  pwm_cmp_chan #(.CNT_W(CNT_W), .IS_A(1'b0)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt_o),
    .cmp(cmp_b_act), .top_eff(top_eff), .om(mode_b), .wave_mode(wave_mode),
    .dir(dir_b), .hit(hit_b), .pin(pwm_b), .oe(oe_b)
  );

endmodule

// File: rtl/pwm_timer16_checker.sv
module pwm_timer16_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic             dir_a,
  input logic             dir_b,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             oe_a,
  input logic             oe_b,
  input logic             tick,
  input logic             wrap,
  input logic             hit_a
);

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b000) |=> $stable(cnt_o)) else $error("stopped counter moved"); // R3

  AST_DIV1_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b001) |-> tick) else $error("no tick at divide by one"); // R3

  AST_WRAP_TO_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_o == '0)) else $error("wrap did not return to zero"); // R2

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a |-> dir_a) and (oe_b |-> dir_b)) else $error("enable without direction"); // R9

  AST_B_TOGGLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'b01) |-> (!pwm_b && !oe_b)) else $error("channel B driven in code 01"); // R8

  AST_NONINV_SET_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode_a == 2'b10) |=> (mode_a != 2'b10 || pwm_a)) else $error("BOTTOM did not set A"); // R5

  AST_NO_HIT_ON_WRAP_NONINV: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode_a[1]) |-> !hit_a) else $error("match at TOP not ignored"); // R7

endmodule

bind pwm_timer16 pwm_timer16_checker #(.CNT_W(CNT_W)) u_pwm_timer16_checker (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode_a(mode_a), .mode_b(mode_b),
  .dir_a(dir_a), .dir_b(dir_b), .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .oe_a(oe_a), .oe_b(oe_b), .tick(tick), .wrap(wrap), .hit_a(hit_a)
);

// File: tb/pwm_timer16_bench.sv
`timescale 1ns/1ps
module pwm_timer16_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = 3'b000;
  logic [3:0]  wave_mode = 4'd14;
  logic [1:0]  mode_a = 2'b00, mode_b = 2'b00;
  logic        dir_a = 1'b0, dir_b = 1'b0;
  logic        ext_clk = 1'b0;
  logic        top_wr = 1'b0, cmp_a_wr = 1'b0, cmp_b_wr = 1'b0;
  logic [15:0] top_din = '0, cmp_a_din = '0, cmp_b_din = '0;
  logic [15:0] cnt_o;
  logic        pwm_a, pwm_b, oe_a, oe_b;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_timer16 u_pwm_timer16 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .mode_a(mode_a), .mode_b(mode_b), .dir_a(dir_a), .dir_b(dir_b),
    .ext_clk(ext_clk), .top_wr(top_wr), .top_din(top_din),
    .cmp_a_wr(cmp_a_wr), .cmp_a_din(cmp_a_din), .cmp_b_wr(cmp_b_wr),
    .cmp_b_din(cmp_b_din), .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .oe_a(oe_a), .oe_b(oe_b)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_p = 0, m_cnt = 0;
  int m_top = 0, m_top_b = 0, m_ca = 0, m_ca_b = 0, m_cb = 0, m_cb_b = 0;
  bit m_oa = 0, m_ob = 0;
  bit smp[$] = '{0, 0, 0};

  function automatic bit chan_next(input logic [1:0] md, input bit cur, input bit bottom,
                                   input bit match, input bit tgl);
    if (md[1]) return bottom ? !md[0] : (match ? md[0] : cur);
    if (md == 2'b01 && tgl && match) return !cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p = 0; m_cnt = 0; m_top = 0; m_top_b = 0; m_ca = 0; m_ca_b = 0;
      m_cb = 0; m_cb_b = 0; m_oa = 0; m_ob = 0; smp = '{0, 0, 0};
    end else begin
      bit rise, fall, tk, at_top;
      int teff;
      rise = smp[1] && !smp[2];
      fall = !smp[1] && smp[2];
      smp.push_front(ext_clk);
      void'(smp.pop_back());
      case (clk_sel)
        3'd0: tk = 0;
        3'd1: tk = 1;
        3'd2: tk = (m_p % 8) == 7;
        3'd3: tk = (m_p % 64) == 63;
        3'd4: tk = (m_p % 256) == 255;
        3'd5: tk = (m_p % 1024) == 1023;
        3'd6: tk = fall;
        default: tk = rise;
      endcase
      m_p = (m_p + 1) % 1024;
      teff = (wave_mode == 4'd15) ? m_ca : m_top;
      if (tk) begin
        at_top = (m_cnt == teff);
        m_oa = chan_next(mode_a, m_oa, at_top, m_cnt == m_ca, wave_mode == 4'd15);
        m_ob = chan_next(mode_b, m_ob, at_top, m_cnt == m_cb, 1'b0);
        m_cnt = at_top ? 0 : (m_cnt + 1) % 65536;
        if (at_top) begin m_top = m_top_b; m_ca = m_ca_b; m_cb = m_cb_b; end
      end
      if (top_wr) m_top_b = top_din;
      if (cmp_a_wr) m_ca_b = cmp_a_din;
      if (cmp_b_wr) m_cb_b = cmp_b_din;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit own_a, own_b;
      own_a = mode_a[1] || (mode_a == 2'b01 && wave_mode == 4'd15);
      own_b = mode_b[1];
      check("R2 count vs model", cnt_o, m_cnt);
      check("R5/R6 pin A vs model", pwm_a, own_a ? m_oa : 0);
      check("R5/R6 pin B vs model", pwm_b, own_b ? m_ob : 0);
      check("R9 enable A vs model", oe_a, own_a && dir_a);
      check("R9 enable B vs model", oe_b, own_b && dir_b);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_top(input int v);
    @(negedge clk); top_wr = 1; top_din = 16'(v);
    @(negedge clk); top_wr = 0;
  endtask

  task automatic write_cmp(input int a, input int b);
    @(negedge clk); cmp_a_wr = 1; cmp_a_din = 16'(a); cmp_b_wr = 1; cmp_b_din = 16'(b);
    @(negedge clk); cmp_a_wr = 0; cmp_b_wr = 0;
  endtask

  task automatic count_high(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      ha += pwm_a; hb += pwm_b;
    end
  endtask

  task automatic wait_count(input int v);
    do begin @(posedge clk); #2; end while (cnt_o != 16'(v));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    int ha, hb, c0, c1, mx, tg;
    bit prev;
    cycles(3);
    check("R1 reset count", cnt_o, 0);
    check("R1 reset pins", {pwm_a, pwm_b, oe_a, oe_b}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    check("R1 first cycle after reset", {cnt_o, pwm_a, pwm_b}, 0);

    // non-inverting A, inverting B, TOP 9, divide by one
    @(negedge clk);
    clk_sel = 3'b001; wave_mode = 4'd14; mode_a = 2'b10; mode_b = 2'b11; dir_a = 1; dir_b = 1;
    write_top(9);
    write_cmp(3, 6);
    cycles(30);
    count_high(10, ha, hb);
    check("R5 non-inverting high counts", ha, 4);
    check("R6 inverting high counts", hb, 3);
    wait_count(0); c0 = 0;
    do begin @(posedge clk); #2; c0++; end while (cnt_o != 0);
    check("R2 period is TOP+1 ticks", c0, 10);

    // mid-period TOP write is held until wrap
    wait_count(2);
    write_top(3);
    mx = 0;
    do begin @(posedge clk); #2; if (cnt_o > mx) mx = cnt_o; end while (cnt_o != 0);
    check("R10 old TOP kept for current period", mx, 9);
    mx = 0;
    do begin @(posedge clk); #2; if (cnt_o > mx) mx = cnt_o; end while (cnt_o != 0);
    check("R10 new TOP after wrap", mx, 3);
    write_top(9);

    // compare 0 and compare equal to TOP
    mode_b = 2'b10;
    write_cmp(0, 9);
    cycles(30);
    count_high(10, ha, hb);
    check("R7 compare zero one-count pulse", ha, 1);
    check("R7 compare equal TOP stays high", hb, 10);
    mode_a = 2'b11; write_cmp(9, 9);
    cycles(30);
    count_high(10, ha, hb);
    check("R7 inverting compare equal TOP stays low", ha, 0);

    // direction gating
    mode_a = 2'b10; write_cmp(4, 5);
    @(negedge clk); dir_a = 0; dir_b = 0;
    @(posedge clk); #2;
    check("R9 enables off without direction", {oe_a, oe_b}, 0);
    @(negedge clk); dir_a = 1; dir_b = 1;

    // divide by 8, then 64
    @(negedge clk); clk_sel = 3'b010;
    cycles(20);
    c0 = 0; prev = 0;
    begin
      int last;
      @(posedge clk); #2; last = cnt_o;
      for (int i = 0; i < 80; i++) begin
        @(posedge clk); #2;
        if (cnt_o != last) c0++;
        last = cnt_o;
      end
    end
    check("R3 divide by 8 gives 10 ticks in 80 clocks", c0, 10);
    @(negedge clk); clk_sel = 3'b011;
    cycles(300);

    // stopped
    @(negedge clk); clk_sel = 3'b000;
    @(posedge clk); #2; c0 = cnt_o;
    cycles(40);
    check("R3 stopped count holds", cnt_o, c0);

    // external rising then falling edges
    @(negedge clk); clk_sel = 3'b111; ext_clk = 0;
    cycles(6);
    @(posedge clk); #2; c0 = cnt_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_clk = 1; cycles(6);
      @(negedge clk); ext_clk = 0; cycles(6);
    end
    cycles(4);
    @(posedge clk); #2; c1 = cnt_o;
    check("R4 four rising edges counted", (c1 - c0 + 10) % 10, 4);
    @(negedge clk); clk_sel = 3'b110;
    cycles(4);
    @(posedge clk); #2; c0 = cnt_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_clk = 1; cycles(6);
      @(negedge clk); ext_clk = 0; cycles(6);
    end
    cycles(4);
    @(posedge clk); #2; c1 = cnt_o;
    check("R4 three falling edges counted", (c1 - c0 + 10) % 10, 3);

    // code 01 outside mode 15: both disconnected
    @(negedge clk); clk_sel = 3'b001; mode_a = 2'b01; mode_b = 2'b01;
    cycles(12);
    check("R8 code 01 in mode 14 leaves A off", {pwm_a, oe_a}, 0);

    // mode 15: TOP from compare A, toggle on A
    write_cmp(4, 2);
    cycles(10);
    @(negedge clk); wave_mode = 4'd15;
    cycles(30);
    check("R8 channel A owned under toggle", oe_a, 1);
    @(posedge clk); #2; prev = pwm_a; tg = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2;
      if (pwm_a != prev) tg++;
      prev = pwm_a;
    end
    check("R8 toggle once per 5-count period", tg, 4);
    check("R8 channel B off under code 01", {pwm_b, oe_b}, 0);
    wait_count(0); c0 = 0;
    do begin @(posedge clk); #2; c0++; end while (cnt_o != 0);
    check("R11 mode 15 period uses compare A", c0, 5);
    @(negedge clk); wave_mode = 4'd3; mode_a = 2'b10;
    cycles(25);
    wait_count(0); c0 = 0;
    do begin @(posedge clk); #2; c0++; end while (cnt_o != 0);
    check("R11 other mode uses TOP register", c0, 10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule